// File: doc/BRIEF.md
# Lane protocol reconfiguration sequencer

This block moves one lane of an eight-lane serial transceiver between a 1 Gb/s mode with 8b/10b coding and a 10 Gb/s mode with 64b/66b coding. A client presents a single-cycle request that carries a lane number and the wanted mode. The sequencer first reads the control words of both clock synthesizers (PLLs) and picks the lowest-numbered enabled PLL whose clock net can carry that mode. If no PLL fits, it rejects the request without writing anything.

When the request is accepted, the block runs a fixed list of register operations over a simple internal register port. The port does single-cycle writes and returns read data in the same cycle. Fields are changed by read-modify-write, so bits outside a field keep their value. The list runs in this order: halt a running lane, empty the lane's slot in the register of the other protocol, fill its slot in the register of the new protocol, set the lane's protocol and datapath width, set the PLL choice and rate divider, switch the 1G PCS, load six equalization words, and finally reset a previously running lane back into service. The analog lane is outside this block. Its registers are modelled by whatever answers on the register port.

Top module: `lane_reconfig_seq`

## Requirements
- R1: A lane's 4-bit slot in the shared protocol registers starts at bit 4*(7-lane), so lane 0 owns bits 31:28. 1G writes 0x1 into the slot at address 0x10A0, and 10G writes 0x9 into the slot at address 0x10B0. All other slots keep their value.
- R2: The lane's slot in the other protocol's register (0x10B0 for a 1G request, 0x10A0 for a 10G request) is cleared to zero, and this write comes before the write that fills the new slot.
- R3: The lane general register (lane base 0x800 + lane*0x100, offset 0x00) gets bits 7:0 = 0x08 for 1G (protocol code 1, width code 0 = 10-bit) and 0x52 for 10G (protocol code 10, width code 2 = 20-bit). Bits 31:8 are preserved.
- R4: Bit 28 of the TX general register (offset 0x24) and of the RX general register (offset 0x44) selects the PLL: 0 for PLL 0, 1 for PLL 1. The PLL chosen is the lowest-numbered one whose control word at 0x400 + n*0x100 has bit 24 (disable) clear and whose frequency field (bits 28:24 of the word at 0x408 + n*0x100) fits the mode. The values 0x00 and 0x10 fit 1G, and 0x06 fits 10G.
- R5: Bits 26:24 of the TX and RX general registers are set to 2 (quarter rate) for 1G and to 0 (full rate) for 10G. Bits outside 28 and 26:24 are preserved.
- R6: Bit 11 of the lane's PCS control register (0x1804 + lane*0x10) is set for 1G and cleared for 10G. Its other bits are preserved.
- R7: Six whole words are written at lane offsets 0x30, 0x48, 0x50, 0x54, 0x58 and 0x74. For 1G they are 0x00808006, 0x04310000, 0x9F800000, 0x001F0000, 0, 0. For 10G they are 0x10808307, 0x10000000, 0, 0x001F0000, 0x81000020, 0x00002000.
- R8: If the lane is marked running when the request is taken, halt bit 27 is set in both reset-control registers (offsets 0x20 and 0x40). The block then waits for the lane to clear both halt bits before it touches any protocol register. At the end it sets reset bit 31 in both registers and waits until bit 30 (reset done) reads 1 in both. A lane that is not running sees none of these writes.
- R9: If no enabled PLL fits the mode, the block makes no register write and ends with done and err high together.
- R10: busy is high from the cycle after a request is taken until the sequence ends. done is a one-cycle pulse. Requests that arrive while busy is high are ignored. The register port is idle while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_lane | input | 3 | Lane number of the request |
| req_10g | input | 1 | Target mode: 1 = 10G, 0 = 1G |
| lane_running | input | 8 | Per-lane flag: lane is currently in service |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | With done: request rejected, no PLL fits |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 16 | Register byte address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the cycle of the read |

## Verification
The embedded assertions check the handshake on every cycle. done never lasts two cycles, err only appears with done, the register port stays silent while idle, a read and a write never share a cycle, and a rejected request ends with no write made. The register values themselves can only be shown by the bench's scenarios: slot positions and slot clearing, PLL choice under different disable and frequency settings, rate, PCS bit, equalization words and the order of halt, slot and reset writes. The bench's register model emulates the lane's halt and reset handshake so that the waiting steps are exercised.

// File: rtl/lrs_pkg.sv
// Shared types, address map and constant tables of the lane reconfiguration
// sequencer. Assumes a 16-bit byte address space with 32-bit registers.
package lrs_pkg;

    typedef enum logic [2:0] {
        OP_SKIP,
        OP_RMW,
        OP_WR,
        OP_POLL,
        OP_END
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [15:0] addr;
        logic [31:0] mask;
        logic [31:0] val;
    } reg_op_t;

    localparam logic [15:0] ADDR_SLOT_1G  = 16'h10A0;
    localparam logic [15:0] ADDR_SLOT_10G = 16'h10B0;
    localparam logic [15:0] ADDR_PLL_BASE = 16'h0400;
    localparam logic [15:0] ADDR_LANE_BASE = 16'h0800;
    localparam logic [15:0] ADDR_PCS_BASE = 16'h1804;

    localparam logic [15:0] OFS_GEN   = 16'h0000;
    localparam logic [15:0] OFS_TXRST = 16'h0020;
    localparam logic [15:0] OFS_TXGEN = 16'h0024;
    localparam logic [15:0] OFS_RXRST = 16'h0040;
    localparam logic [15:0] OFS_RXGEN = 16'h0044;

    localparam logic [31:0] BIT_HALT  = 32'h0800_0000;
    localparam logic [31:0] BIT_RST   = 32'h8000_0000;
    localparam logic [31:0] BIT_RDONE = 32'h4000_0000;
    localparam logic [31:0] BIT_PCS   = 32'h0000_0800;
    localparam logic [31:0] MSK_CLKSEL = 32'h1700_0000;

    // Lane-relative offset of equalization word k.
    function automatic logic [15:0] eq_offset(input logic [2:0] k);
        case (k)
            3'd0:    return 16'h0030;
            3'd1:    return 16'h0048;
            3'd2:    return 16'h0050;
            3'd3:    return 16'h0054;
            3'd4:    return 16'h0058;
            default: return 16'h0074;
        endcase
    endfunction

    // Equalization word k for the chosen mode.
    function automatic logic [31:0] eq_value(input logic is10g, input logic [2:0] k);
        case (k)
            3'd0:    return is10g ? 32'h1080_8307 : 32'h0080_8006;
            3'd1:    return is10g ? 32'h1000_0000 : 32'h0431_0000;
            3'd2:    return is10g ? 32'h0000_0000 : 32'h9F80_0000;
            3'd3:    return 32'h001F_0000;
            3'd4:    return is10g ? 32'h8100_0020 : 32'h0000_0000;
            default: return is10g ? 32'h0000_2000 : 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/lrs_pll_pick.sv
// Chooses the lowest-numbered enabled PLL whose clock net suits the mode.
// Assumes the disable flags and frequency fields were captured beforehand.
module lrs_pll_pick #(
    parameter int NPLL = 2,
    parameter int PW   = 1
) (
    input  logic [NPLL-1:0]      pll_dis,
    input  logic [NPLL-1:0][4:0] pll_freq,
    input  logic                 want_10g,
    output logic                 found,
    output logic [PW-1:0]        pick
);

    logic [NPLL-1:0] fits;

    genvar g;
    generate
        for (g = 0; g < NPLL; g++) begin : g_fit
            // Per-PLL suitability: enabled, and the net matches the mode.
            assign fits[g] = !pll_dis[g] &&
                (want_10g ? (pll_freq[g] == 5'h06)
                          : (pll_freq[g] == 5'h00 || pll_freq[g] == 5'h10));
        end
    endgenerate

    // Priority pick: scanning downward leaves the lowest fitting index.
    always_comb begin
        found = |fits;
        pick  = '0;
        for (int i = NPLL - 1; i >= 0; i--) begin
            if (fits[i]) pick = PW'(i);
        end
    end

endmodule

// File: rtl/lrs_step_gen.sv
// Maps a step number to one register operation of the fixed reconfiguration
// list. Assumes NLANE*4 <= 32 so that every lane slot fits one word.
module lrs_step_gen
    import lrs_pkg::*;
#(
    parameter int NLANE = 8,
    parameter int LW    = 3,
    parameter int PW    = 1
) (
    input  logic [4:0]    step,
    input  logic [LW-1:0] lane,
    input  logic          want_10g,
    input  logic [PW-1:0] pll_idx,
    input  logic          running,
    output reg_op_t       op
);

    logic [15:0] lbase;
    logic [15:0] pcs_addr;
    logic [4:0]  sh;
    logic [31:0] slot_mask;
    logic [31:0] clk_sel;
    logic [2:0]  eq_k;

    // Lane-dependent addresses, slot position and clock selection word.
    always_comb begin
        lbase     = ADDR_LANE_BASE + (16'(lane) << 8);
        pcs_addr  = ADDR_PCS_BASE + (16'(lane) << 4);
        sh        = 5'(4 * (NLANE - 1) - 4 * int'(lane));
        slot_mask = 32'hF << sh;
        clk_sel   = {3'b000, (pll_idx != '0), 1'b0,
                     (want_10g ? 3'd0 : 3'd2), 24'h0};
        eq_k      = 3'(step - 5'd10);
    end

    // Operation list: halt, slot clear, slot set, lane fields, EQ, resume.
    always_comb begin
        op = '{kind: OP_END, addr: 16'h0, mask: 32'h0, val: 32'h0};
        case (step)
            5'd0: op = running ? '{OP_RMW, lbase + OFS_TXRST, BIT_HALT, BIT_HALT}
                               : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd1: op = running ? '{OP_RMW, lbase + OFS_RXRST, BIT_HALT, BIT_HALT}
                               : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd2: op = running ? '{OP_POLL, lbase + OFS_TXRST, BIT_HALT, 32'h0}
                               : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd3: op = running ? '{OP_POLL, lbase + OFS_RXRST, BIT_HALT, 32'h0}
                               : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd4: op = '{OP_RMW, want_10g ? ADDR_SLOT_1G : ADDR_SLOT_10G,
                         slot_mask, 32'h0};
            5'd5: op = '{OP_RMW, want_10g ? ADDR_SLOT_10G : ADDR_SLOT_1G,
                         slot_mask, (want_10g ? 32'h9 : 32'h1) << sh};
            5'd6: op = '{OP_RMW, lbase + OFS_GEN, 32'hFF,
                         want_10g ? 32'h52 : 32'h08};
            5'd7: op = '{OP_RMW, lbase + OFS_TXGEN, MSK_CLKSEL, clk_sel};
            5'd8: op = '{OP_RMW, lbase + OFS_RXGEN, MSK_CLKSEL, clk_sel};
            5'd9: op = '{OP_RMW, pcs_addr, BIT_PCS, want_10g ? 32'h0 : BIT_PCS};
            5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15:
                  op = '{OP_WR, lbase + eq_offset(eq_k), 32'hFFFF_FFFF,
                         eq_value(want_10g, eq_k)};
            5'd16: op = running ? '{OP_RMW, lbase + OFS_TXRST, BIT_RST, BIT_RST}
                                : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd17: op = running ? '{OP_RMW, lbase + OFS_RXRST, BIT_RST, BIT_RST}
                                : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd18: op = running ? '{OP_POLL, lbase + OFS_TXRST, BIT_RDONE, BIT_RDONE}
                                : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            5'd19: op = running ? '{OP_POLL, lbase + OFS_RXRST, BIT_RDONE, BIT_RDONE}
                                : '{OP_SKIP, 16'h0, 32'h0, 32'h0};
            default: op = '{OP_END, 16'h0, 32'h0, 32'h0};
        endcase
    end

endmodule

// File: rtl/lane_reconfig_seq.sv
// Top of the lane reconfiguration sequencer. It takes one request at a time,
// reads the PLL words, rejects the request if no PLL fits, and otherwise walks
// the operation list over the register port. It assumes read data is valid
// in the cycle of the read and that the lane model clears halt and reset bits
// by itself.
module lane_reconfig_seq
    import lrs_pkg::*;
#(
    parameter int NLANE = 8,
    parameter int NPLL  = 2,
    parameter int LW    = $clog2(NLANE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LW-1:0]    req_lane,
    input  logic             req_10g,
    input  logic [NLANE-1:0] lane_running,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [15:0]      reg_addr,
    output logic [31:0]      reg_wdata,
    input  logic [31:0]      reg_rdata
);

    localparam int PW  = (NPLL > 1) ? $clog2(NPLL) : 1;
    localparam int RDN = 2 * NPLL;
    localparam int RW  = $clog2(RDN);

    typedef enum logic [2:0] {S_IDLE, S_PLLRD, S_CHECK, S_OP, S_OPWR} state_e;

    state_e               state;
    logic [LW-1:0]        cur_lane;
    logic                 cur_10g;
    logic                 cur_run;
    logic [RW-1:0]        rd_idx;
    logic [NPLL-1:0]      pll_dis;
    logic [NPLL-1:0][4:0] pll_freq;
    logic [PW-1:0]        pll_sel;
    logic [4:0]           step;
    logic [31:0]          hold;
    logic                 done_q;
    logic                 err_q;
    logic                 wrote;
    logic                 pick_found;
    logic [PW-1:0]        pick_idx;
    reg_op_t              op;
    logic [PW-1:0]        rd_pll;

    assign rd_pll = PW'(rd_idx >> 1);

    lrs_pll_pick #(.NPLL(NPLL), .PW(PW)) u_pick (
        .pll_dis  (pll_dis),
        .pll_freq (pll_freq),
        .want_10g (cur_10g),
        .found    (pick_found),
        .pick     (pick_idx)
    );

    lrs_step_gen #(.NLANE(NLANE), .LW(LW), .PW(PW)) u_steps (
        .step     (step),
        .lane     (cur_lane),
        .want_10g (cur_10g),
        .pll_idx  (pll_sel),
        .running  (cur_run),
        .op       (op)
    );

    assign busy = (state != S_IDLE);
    assign done = done_q;
    assign err  = err_q;

    // Register port drive for the current state and operation.
    always_comb begin
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = 16'h0;
        reg_wdata = 32'h0;
        case (state)
            S_PLLRD: begin
                reg_rd   = 1'b1;
                reg_addr = ADDR_PLL_BASE + (16'(rd_pll) << 8) +
                           (rd_idx[0] ? 16'h8 : 16'h0);
            end
            S_OP: begin
                if (op.kind == OP_RMW || op.kind == OP_POLL) begin
                    reg_rd   = 1'b1;
                    reg_addr = op.addr;
                end else if (op.kind == OP_WR) begin
                    reg_wr    = 1'b1;
                    reg_addr  = op.addr;
                    reg_wdata = op.val;
                end
            end
            S_OPWR: begin
                reg_wr    = 1'b1;
                reg_addr  = op.addr;
                reg_wdata = (hold & ~op.mask) | op.val;
            end
            default: ;
        endcase
    end

    // Sequencer state, request capture, PLL capture and step advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_lane <= '0;
            cur_10g  <= 1'b0;
            cur_run  <= 1'b0;
            rd_idx   <= '0;
            pll_dis  <= '0;
            pll_freq <= '0;
            pll_sel  <= '0;
            step     <= '0;
            hold     <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            wrote    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (reg_wr) wrote <= 1'b1;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_lane <= req_lane;
                        cur_10g  <= req_10g;
                        cur_run  <= lane_running[req_lane];
                        rd_idx   <= '0;
                        wrote    <= 1'b0;
                        state    <= S_PLLRD;
                    end
                end
                S_PLLRD: begin
                    if (rd_idx[0]) pll_freq[rd_pll] <= reg_rdata[28:24];
                    else           pll_dis[rd_pll]  <= reg_rdata[24];
                    if (rd_idx == RW'(RDN - 1)) state <= S_CHECK;
                    else                        rd_idx <= rd_idx + 1'b1;
                end
                S_CHECK: begin
                    if (pick_found) begin
                        pll_sel <= pick_idx;
                        step    <= '0;
                        state   <= S_OP;
                    end else begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                S_OP: begin
                    case (op.kind)
                        OP_SKIP, OP_WR: step <= step + 1'b1;
                        OP_RMW: begin
                            hold  <= reg_rdata;
                            state <= S_OPWR;
                        end
                        OP_POLL: begin
                            if ((reg_rdata & op.mask) == op.val) step <= step + 1'b1;
                        end
                        default: begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end
                    endcase
                end
                S_OPWR: begin
                    step  <= step + 1'b1;
                    state <= S_OP;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_wr && !reg_rd));

    assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_err_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_reject_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !wrote);

endmodule

// File: tb/lane_reconfig_seq_bench.sv
// Directed bench: a register-file model answers the port and emulates the
// lane's halt and reset handshake; one task per scenario.
module lane_reconfig_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_lane = 3'd0;
    logic        req_10g = 1'b0;
    logic [7:0]  lane_running = 8'h20;
    logic        busy, done, err, reg_rd, reg_wr;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    logic [31:0] regs [0:2047];
    logic        poke_en = 1'b0;
    logic [15:0] poke_addr = 16'h0;
    logic [31:0] poke_data = 32'h0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0, n_wr = 0, n_halt = 0, n_rst = 0, n_done = 0;
    int t_a = 0, t_b = 0, t_halt = 0, t_rst = 0;

    always #5 clk = ~clk;

    lane_reconfig_seq u_lane_reconfig_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane(req_lane),
        .req_10g(req_10g), .lane_running(lane_running), .busy(busy),
        .done(done), .err(err), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr[12:2]];

    initial begin
        for (int i = 0; i < 2048; i++) regs[i] = 32'h0;
    end

    // Register model, write log and lane handshake emulation.
    always @(posedge clk) begin
        int w;
        cyc <= cyc + 1;
        if (done) n_done <= n_done + 1;
        if (poke_en) regs[poke_addr[12:2]] <= poke_data;
        if (reg_wr) begin
            regs[reg_addr[12:2]] <= reg_wdata;
            n_wr <= n_wr + 1;
            if (reg_addr == 16'h10A0) t_a <= cyc;
            if (reg_addr == 16'h10B0) t_b <= cyc;
            if (reg_addr >= 16'h0800 && reg_addr < 16'h1000 &&
                (reg_addr[7:0] == 8'h20 || reg_addr[7:0] == 8'h40)) begin
                if (reg_wdata[27]) begin n_halt <= n_halt + 1; t_halt <= cyc; end
                if (reg_wdata[31]) begin n_rst <= n_rst + 1; t_rst <= cyc; end
            end
        end
        if (cyc % 4 == 3) begin
            for (int l = 0; l < 8; l++) begin
                for (int r = 0; r < 2; r++) begin
                    w = (32'h800 + l * 256 + (r == 1 ? 32'h40 : 32'h20)) >> 2;
                    if (!(reg_wr && reg_addr[12:2] == 11'(w))) begin
                        if (regs[w][27])
                            regs[w] <= regs[w] & ~32'h4800_0000;
                        else if (regs[w][31])
                            regs[w] <= (regs[w] & ~32'h8000_0000) | 32'h4000_0000;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_reg(input string tag, input logic [15:0] a, input logic [31:0] exp);
        check(tag, regs[a[12:2]], exp);
    endtask

    task automatic poke(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_plls(input logic [31:0] r0, input logic [31:0] c0,
                            input logic [31:0] r1, input logic [31:0] c1);
        poke(16'h0400, r0); poke(16'h0408, c0);
        poke(16'h0500, r1); poke(16'h0508, c1);
    endtask

    task automatic wait_done(output logic got_err);
        int k = 0;
        while (!done && k < 3000) begin @(negedge clk); k++; end
        if (!done) begin
            n_fail++;
            $display("FAIL R10: actual no done pulse expected done within 3000 cycles");
        end
        got_err = err;
    endtask

    task automatic run_req(input logic [2:0] lane, input logic is10g, output logic got_err);
        @(negedge clk);
        req_valid = 1'b1; req_lane = lane; req_10g = is10g;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(got_err);
    endtask

    function automatic logic [31:0] eq_exp(input logic is10g, input int k);
        case (k)
            0: return is10g ? 32'h1080_8307 : 32'h0080_8006;
            1: return is10g ? 32'h1000_0000 : 32'h0431_0000;
            2: return is10g ? 32'h0 : 32'h9F80_0000;
            3: return 32'h001F_0000;
            4: return is10g ? 32'h8100_0020 : 32'h0;
            default: return is10g ? 32'h0000_2000 : 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] eq_ofs(input int k);
        case (k)
            0: return 16'h30; 1: return 16'h48; 2: return 16'h50;
            3: return 16'h54; 4: return 16'h58; default: return 16'h74;
        endcase
    endfunction

    task automatic t_reset;
        check("R10 busy after reset", {31'h0, busy}, 32'h0);
        check("R10 done after reset", {31'h0, done}, 32'h0);
        check("R10 err after reset", {31'h0, err}, 32'h0);
        check("R10 port idle after reset", {30'h0, reg_wr, reg_rd}, 32'h0);
    endtask

    // Lane 0 from 10G to 1G, lane idle; PLL1 is the only 1G net.
    task automatic t_lane0_1g;
        logic e;
        int w0, h0, r0;
        set_plls(32'h0, 32'h0600_0000, 32'h0, 32'h0000_0000);
        poke(16'h10A0, 32'h0000_0010);
        poke(16'h10B0, 32'h9000_0000);
        poke(16'h0800, 32'hABCD_00FF);
        poke(16'h0824, 32'h0);
        poke(16'h0844, 32'h0);
        poke(16'h1804, 32'h0000_0001);
        poke(16'h0858, 32'hDEAD_BEEF);
        poke(16'h0874, 32'hDEAD_BEEF);
        w0 = n_wr; h0 = n_halt; r0 = n_rst;
        run_req(3'd0, 1'b0, e);
        check("R9 lane0 1G err", {31'h0, e}, 32'h0);
        expect_reg("R1 lane0 slot set in 1G reg", 16'h10A0, 32'h1000_0010);
        expect_reg("R2 lane0 slot cleared in 10G reg", 16'h10B0, 32'h0);
        check("R2 clear before set (1G)", {31'h0, (t_b < t_a)}, 32'h1);
        expect_reg("R3 lane0 general 1G", 16'h0800, 32'hABCD_0008);
        expect_reg("R4 R5 lane0 TX PLL1 quarter", 16'h0824, 32'h1200_0000);
        expect_reg("R4 R5 lane0 RX PLL1 quarter", 16'h0844, 32'h1200_0000);
        expect_reg("R6 lane0 PCS on", 16'h1804, 32'h0000_0801);
        for (int k = 0; k < 6; k++)
            expect_reg($sformatf("R7 lane0 EQ word %0d", k), 16'h0800 + eq_ofs(k), eq_exp(1'b0, k));
        check("R8 idle lane no halt", n_halt - h0, 0);
        check("R8 idle lane no reset", n_rst - r0, 0);
        check("R10 writes made", {31'h0, (n_wr - w0) > 0}, 32'h1);
    endtask

    // Lane 5 from 1G to 10G while running; PLL0 is the 10G net.
    task automatic t_lane5_10g_running;
        logic e;
        int h0, r0;
        poke(16'h10A0, 32'h1000_0110);
        poke(16'h10B0, 32'h0);
        poke(16'h0D00, 32'h0000_0008);
        poke(16'h0D24, 32'h1200_00AA);
        poke(16'h0D44, 32'h1200_00AA);
        poke(16'h1854, 32'h0000_0801);
        poke(16'h0D50, 32'h1234_5678);
        poke(16'h0D20, 32'h4000_0000);
        poke(16'h0D40, 32'h4000_0000);
        h0 = n_halt; r0 = n_rst;
        run_req(3'd5, 1'b1, e);
        check("R9 lane5 10G err", {31'h0, e}, 32'h0);
        expect_reg("R1 lane5 slot set in 10G reg", 16'h10B0, 32'h0000_0900);
        expect_reg("R2 lane5 slot cleared, others kept", 16'h10A0, 32'h1000_0010);
        check("R2 clear before set (10G)", {31'h0, (t_a < t_b)}, 32'h1);
        expect_reg("R3 lane5 general 10G", 16'h0D00, 32'h0000_0052);
        expect_reg("R4 R5 lane5 TX PLL0 full", 16'h0D24, 32'h0000_00AA);
        expect_reg("R4 R5 lane5 RX PLL0 full", 16'h0D44, 32'h0000_00AA);
        expect_reg("R6 lane5 PCS off", 16'h1854, 32'h0000_0001);
        for (int k = 0; k < 6; k++)
            expect_reg($sformatf("R7 lane5 EQ word %0d", k), 16'h0D00 + eq_ofs(k), eq_exp(1'b1, k));
        check("R8 halt writes", n_halt - h0, 2);
        check("R8 reset writes", n_rst - r0, 2);
        check("R8 halt before slot clear", {31'h0, (t_halt < t_a)}, 32'h1);
        check("R8 reset after slot set", {31'h0, (t_rst > t_b)}, 32'h1);
        expect_reg("R8 TX back in service", 16'h0D20, 32'h4000_0000);
        expect_reg("R8 RX back in service", 16'h0D40, 32'h4000_0000);
    endtask

    // 1G request with the only 1G-capable PLL disabled.
    task automatic t_reject;
        logic e;
        int w0;
        set_plls(32'h0, 32'h0600_0000, 32'h0100_0000, 32'h0000_0000);
        poke(16'h0A00, 32'h0000_0033);
        w0 = n_wr;
        run_req(3'd2, 1'b0, e);
        check("R9 reject err", {31'h0, e}, 32'h1);
        check("R9 reject no writes", n_wr - w0, 0);
        expect_reg("R9 lane2 general untouched", 16'h0A00, 32'h0000_0033);
        expect_reg("R9 1G slot reg untouched", 16'h10A0, 32'h1000_0010);
    endtask

    // First enabled fitting PLL wins; code 0x10 counts as a 1G net.
    task automatic t_first_enabled;
        logic e;
        set_plls(32'h0100_0000, 32'h0600_0000, 32'h0, 32'h0600_0000);
        run_req(3'd3, 1'b1, e);
        check("R4 lane3 err", {31'h0, e}, 32'h0);
        expect_reg("R4 lane3 TX skips disabled PLL0", 16'h0B24, 32'h1000_0000);
        expect_reg("R4 lane3 RX skips disabled PLL0", 16'h0B44, 32'h1000_0000);
        set_plls(32'h0, 32'h1000_0000, 32'h0, 32'h0000_0000);
        run_req(3'd7, 1'b0, e);
        check("R4 lane7 err", {31'h0, e}, 32'h0);
        expect_reg("R4 lane7 TX lowest PLL0", 16'h0F24, 32'h0200_0000);
        expect_reg("R1 lane7 slot at bits 3:0", 16'h10A0, 32'h1000_0011);
    endtask

    // A second request during a run is ignored.
    task automatic t_busy_ignore;
        logic e;
        int d0;
        set_plls(32'h0, 32'h0600_0000, 32'h0, 32'h0000_0000);
        poke(16'h0C00, 32'h0);
        d0 = n_done;
        @(negedge clk);
        req_valid = 1'b1; req_lane = 3'd1; req_10g = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 busy during run", {31'h0, busy}, 32'h1);
        req_valid = 1'b1; req_lane = 3'd4; req_10g = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done(e);
        repeat (200) @(negedge clk);
        check("R10 one done pulse", n_done - d0, 1);
        check("R10 idle afterwards", {31'h0, busy}, 32'h0);
        expect_reg("R10 lane4 untouched", 16'h0C00, 32'h0);
        expect_reg("R3 lane1 general 10G", 16'h0900, 32'h0000_0052);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lane0_1g();
        t_lane5_10g_running();
        t_reject();
        t_first_enabled();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule